// File: doc/BRIEF.md
# Boot Vector Table Checksum Checker

This block checks the integrity word of a boot image before control is handed to user code. After a start pulse it reads the first 32 bytes of the image (eight 32-bit vector table entries) through a byte-wide memory read port. It fetches one byte per accepted beat and builds each entry in little-endian order. It keeps a wraparound 32-bit running sum of the entries.

The scan produces two results. The pass verdict is set when all eight entries add to zero modulo 2^32. The patch word is the negated sum of entries 0 through 6, which is the value entry 7 must hold for the image to pass. A boot sequencer uses the verdict to decide whether to jump. An image-building flow can read the patch word to fix up the table.

Top module: `vtab_sum_check`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) returns the block to idle: rd_req, done and pass go low and patch becomes 0. This applies in the middle of a scan as well.
- R2: When a scan is accepted, rd_req goes high and rd_addr starts at 0. rd_addr advances by one only on a cycle where rd_req and rd_valid are both high, and it holds its value while rd_valid is low. The scan presents each of addresses 0 to 31 exactly once, in ascending order.
- R3: Entries are little-endian. The byte at address 4*i+k supplies bits 8k+7:8k of entry i (k = 0..3), so entry i spans byte addresses 4*i to 4*i+3. The lane is taken from rd_addr[1:0].
- R4: The sum is taken modulo 2^32. A carry out of bit 31 is dropped and raises no flag, so entries whose true sum is a multiple of 2^32 pass.
- R5: patch equals 0 minus (entry0 + ... + entry6), modulo 2^32. It is valid from the cycle after the byte at address 27 is accepted, and it holds until the next accepted start.
- R6: done is high for exactly one cycle: the cycle after the byte at address 31 is accepted, with rd_req low from then on. In that same cycle pass reads 1 exactly when entry0 + ... + entry7 is 0 modulo 2^32. pass then holds until the next accepted start.
- R7: A start pulse while rd_req is high is ignored: the address sequence and the results do not change.
- R8: Any number of wait cycles (rd_valid low) between beats leaves the results unchanged.
- R9: An accepted start clears pass and patch to 0 from the next cycle until new results are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse that starts a scan when the block is idle |
| rd_req | output | 1 | High while a scan is running and a byte is wanted |
| rd_addr | output | 5 | Byte address of the requested byte |
| rd_valid | input | 1 | rd_data holds the byte at rd_addr; the beat is taken this cycle |
| rd_data | input | 8 | Byte read from the image |
| done | output | 1 | One-cycle pulse when the scan has finished |
| pass | output | 1 | Entries 0 to 7 sum to zero (valid from done) |
| patch | output | 32 | Entry-7 value that would make the image pass |

## Verification
A slipped address counter shows up at rd_addr on the next accepted beat as an address out of sequence. It also shows up at the end as a beat count other than 32. A wrong lane position or a wrong partial word changes the patch word as soon as address 27 is consumed, one cycle later. A wrong accumulator state appears either in the patch word at that point or in the pass verdict in the done cycle. A stuck sequencer shows up as a missing done pulse, and a stray start shows up as a restart of the address sequence within one cycle.

// File: rtl/vtab_pkg.sv
package vtab_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = 4;
  localparam int unsigned WORD_W = BYTE_W * LANES;
  localparam int unsigned LANE_W = $clog2(LANES);

  // Move a byte into its little-endian lane of a word
  function automatic logic [WORD_W-1:0] lane_place(input logic [BYTE_W-1:0] b,
                                                   input logic [LANE_W-1:0] lane);
    return WORD_W'(b) << (BYTE_W * lane);
  endfunction

  // Two's-complement negation modulo 2^WORD_W
  function automatic logic [WORD_W-1:0] twos_neg(input logic [WORD_W-1:0] v);
    return WORD_W'(0) - v;
  endfunction

  // Wraparound add, carry out dropped
  function automatic logic [WORD_W-1:0] wrap_add(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
    return a + b;
  endfunction
endpackage

// File: rtl/vtab_seq.sv
module vtab_seq #(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned LAST_ADDR = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_valid,
  output logic              busy,
  output logic [ADDR_W-1:0] addr,
  output logic              start_ok,
  output logic              beat,
  output logic              done
);
  logic at_last;

  assign start_ok = start && !busy;
  assign beat     = busy && rd_valid;
  assign at_last  = (addr == ADDR_W'(LAST_ADDR));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      addr <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_ok) begin
        busy <= 1'b1;
        addr <= '0;
      end else if (beat) begin
        if (at_last) begin
          busy <= 1'b0;
          done <= 1'b1;
          addr <= '0;
        end else begin
          addr <= addr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vtab_word_asm.sv
module vtab_word_asm
  import vtab_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              beat,
  input  logic [LANE_W-1:0] lane,
  input  logic [BYTE_W-1:0] data,
  output logic [WORD_W-1:0] word_next,
  output logic              word_done
);
  logic [WORD_W-1:0] part_q;
  logic [WORD_W-1:0] base;

  // Lane 0 starts a fresh word; other lanes add to the partial word
  assign base      = (lane == '0) ? '0 : part_q;
  assign word_next = base | lane_place(data, lane);
  assign word_done = beat && (lane == LANE_W'(LANES - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) part_q <= '0;
    else if (beat)    part_q <= word_next;
  end
endmodule

// File: rtl/vtab_accum.sv
module vtab_accum
  import vtab_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned IDX_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              word_done,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [WORD_W-1:0] word_in,
  output logic              patch_load,
  output logic              pass,
  output logic [WORD_W-1:0] patch
);
  localparam int unsigned PATCH_SRC = NUM_WORDS - 2;
  localparam int unsigned FINAL_IDX = NUM_WORDS - 1;

  logic [WORD_W-1:0] sum_q;
  logic [WORD_W-1:0] sum_next;
  logic              final_load;

  assign sum_next   = wrap_add(sum_q, word_in);
  assign patch_load = word_done && (word_idx == IDX_W'(PATCH_SRC));
  assign final_load = word_done && (word_idx == IDX_W'(FINAL_IDX));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sum_q <= '0;
      pass  <= 1'b0;
      patch <= '0;
    end else if (word_done) begin
      sum_q <= sum_next;
      if (patch_load) patch <= twos_neg(sum_next);
      if (final_load) pass  <= (sum_next == '0);
    end
  end
endmodule

// File: rtl/vtab_sum_check.sv
module vtab_sum_check
  import vtab_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 8,
  localparam int unsigned NUM_BYTES = NUM_WORDS * LANES,
  localparam int unsigned ADDR_W    = $clog2(NUM_BYTES),
  localparam int unsigned IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              done,
  output logic              pass,
  output logic [WORD_W-1:0] patch
);
  // Named internal events, visible to the bound checker
  logic              ev_start_ok;
  logic              ev_beat;
  logic              ev_word_done;
  logic              ev_patch_load;
  logic [WORD_W-1:0] word_next;

  vtab_seq #(.ADDR_W(ADDR_W), .LAST_ADDR(NUM_BYTES - 1)) u_seq (
    .clk(clk), .rst(rst), .start(start), .rd_valid(rd_valid),
    .busy(rd_req), .addr(rd_addr), .start_ok(ev_start_ok),
    .beat(ev_beat), .done(done)
  );

  vtab_word_asm u_asm (
    .clk(clk), .rst(rst), .clear(ev_start_ok), .beat(ev_beat),
    .lane(rd_addr[LANE_W-1:0]), .data(rd_data),
    .word_next(word_next), .word_done(ev_word_done)
  );

  vtab_accum #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_acc (
    .clk(clk), .rst(rst), .clear(ev_start_ok), .word_done(ev_word_done),
    .word_idx(rd_addr[ADDR_W-1:LANE_W]), .word_in(word_next),
    .patch_load(ev_patch_load), .pass(pass), .patch(patch)
  );
endmodule

// File: rtl/vtab_sum_check_sva.sv
module vtab_sum_check_sva #(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned LAST_A   = 31,
  parameter int unsigned PATCH_A  = 27
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic              done,
  input logic              pass,
  input logic [WORD_W-1:0] patch,
  input logic              ev_patch_load
);
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid && !done) |=> (rd_req && $stable(rd_addr)));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_valid && rd_addr != ADDR_W'(LAST_A)) |=>
      (rd_req && rd_addr == $past(rd_addr) + 1'b1));

  assert_patch_point_R5: assert property (@(posedge clk) disable iff (rst)
    ev_patch_load |-> (rd_req && rd_addr == ADDR_W'(PATCH_A)));

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_valid && rd_addr == ADDR_W'(LAST_A)) |=> (done && !rd_req));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!rd_req && !start) |=> ($stable(pass) && $stable(patch) && !rd_req));

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_req && start && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  assert_start_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (start && !rd_req) |=> (rd_req && !pass && patch == '0 && rd_addr == '0));
endmodule

bind vtab_sum_check vtab_sum_check_sva #(
  .ADDR_W(ADDR_W), .WORD_W(vtab_pkg::WORD_W),
  .LAST_A(NUM_BYTES - 1), .PATCH_A(NUM_BYTES - vtab_pkg::LANES - 1)
) u_sva (
  .clk(clk), .rst(rst), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .done(done), .pass(pass), .patch(patch),
  .ev_patch_load(ev_patch_load)
);

// File: tb/sim_vtab_sum_check.sv
`timescale 1ns/1ps
module sim_vtab_sum_check;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        rd_req;
  logic [4:0]  rd_addr;
  logic        rd_valid = 1'b0;
  logic [7:0]  rd_data;
  logic        done;
  logic        pass;
  logic [31:0] patch;

  logic [7:0]  img [32];
  int          checks = 0;
  int          errors = 0;
  int          stall_mode = 0;
  int          mon_idx = 0;
  int          mon_err = 0;
  logic        p27_pending = 1'b0;
  logic [31:0] exp_patch_g = '0;
  logic [15:0] lfsr = 16'hACE1;
  int          cyc = 0;

  always #4 clk = ~clk;  // 125 MHz

  vtab_sum_check u0 (
    .clk(clk), .rst(rst), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .pass(pass), .patch(patch)
  );

  assign rd_data = img[rd_addr];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory responder and address monitor, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (p27_pending) begin
      p27_pending = 1'b0;
      check("R5", "patch right after byte 27", patch, exp_patch_g);
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (stall_mode)
      0: rd_valid = 1'b1;
      1: rd_valid = (lfsr[1:0] != 2'b00);
      default: rd_valid = (cyc % 5 == 0);
    endcase
    if (rd_req && rd_valid) begin
      if (rd_addr != 5'(mon_idx)) mon_err++;
      if (rd_addr == 5'd27) p27_pending = 1'b1;
      mon_idx++;
    end
  end

  // Entry i from the bench's own view: lowest address is least significant
  function automatic logic [31:0] entry(input int i);
    return {img[4*i+3], img[4*i+2], img[4*i+1], img[4*i]};
  endfunction

  function automatic logic [31:0] bench_patch();
    logic [32:0] s = '0;
    for (int i = 0; i < 7; i++) s = {1'b0, s[31:0]} + {1'b0, entry(i)};
    return (~s[31:0]) + 32'd1;
  endfunction

  function automatic logic bench_pass();
    logic [31:0] s = '0;
    for (int i = 0; i < 8; i++) s = s + entry(i);
    return (s == 32'd0);
  endfunction

  task automatic put_word(input int i, input logic [31:0] w);
    for (int k = 0; k < 4; k++) img[4*i+k] = w[8*k +: 8];
  endtask

  // Raw bytes as listed in address order
  task automatic put_raw(input int i, input logic [31:0] r);
    img[4*i] = r[31:24]; img[4*i+1] = r[23:16]; img[4*i+2] = r[15:8]; img[4*i+3] = r[7:0];
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Full scan: extra_start_at >= 0 pulses start again that many cycles in
  task automatic run_scan(input string req, input int smode, input logic exp_pass,
                          input logic [31:0] exp_patch, input int extra_start_at);
    int n = 0;
    @(negedge clk);
    stall_mode = smode;
    mon_idx = 0; mon_err = 0; exp_patch_g = exp_patch;
    pulse_start();
    while (!done && n < 3000) begin
      if (n == extra_start_at) pulse_start();
      else @(negedge clk);
      n++;
    end
    check(req, "done seen", {31'd0, done}, 32'd1);
    check(req, "rd_req low at done", {31'd0, rd_req}, 32'd0);
    check(req, "pass", {31'd0, pass}, {31'd0, exp_pass});
    check(req, "patch", patch, exp_patch);
    check("R2", "beats accepted", 32'(mon_idx), 32'd32);
    check("R2", "address order errors", 32'(mon_err), 32'd0);
    @(negedge clk);
    check("R6", "done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset();
    check("R1", "rd_req after reset", {31'd0, rd_req}, 32'd0);
    check("R1", "done after reset", {31'd0, done}, 32'd0);
    check("R1", "pass after reset", {31'd0, pass}, 32'd0);
    check("R1", "patch after reset", patch, 32'd0);
  endtask

  task automatic t_example();
    put_raw(0, 32'h68020010); put_raw(1, 32'h69010000); put_raw(2, 32'h71010000);
    put_raw(3, 32'h73010000); put_raw(4, 32'h75010000); put_raw(5, 32'h77010000);
    put_raw(6, 32'h79010000); put_raw(7, 32'hE6F4FFEF);
    check("R3", "entry 0 assembled by bench", entry(0), 32'h10000268);
    run_scan("R6", 0, 1'b1, 32'hEFFFF4E6, -1);
  endtask

  task automatic t_corrupt_stall();
    img[28] = 8'hE7;
    run_scan("R8", 1, 1'b0, 32'hEFFFF4E6, -1);
    run_scan("R8", 2, 1'b0, 32'hEFFFF4E6, -1);
  endtask

  task automatic t_lanes();
    for (int b = 0; b < 32; b++) img[b] = 8'h00;
    img[0] = 8'h01; img[5] = 8'h02; img[10] = 8'h04; img[15] = 8'h08;
    img[16] = 8'h10; img[21] = 8'h20; img[26] = 8'h40; img[31] = 8'h80;
    run_scan("R3", 0, 1'b0, bench_patch(), -1);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 8; i++) put_word(i, 32'h20000000);
    run_scan("R4", 1, 1'b1, 32'h20000000, -1);
  endtask

  task automatic t_random(input int seed);
    logic [31:0] x = 32'h1234567 + 32'(seed);
    for (int i = 0; i < 7; i++) begin
      x = x * 32'd1103515245 + 32'd12345;
      put_word(i, x);
    end
    put_word(7, bench_patch());
    run_scan("R5", seed % 3, bench_pass(), bench_patch(), -1);
  endtask

  task automatic t_start_ignored();
    run_scan("R7", 0, bench_pass(), bench_patch(), 6);
    run_scan("R7", 2, bench_pass(), bench_patch(), 20);
  endtask

  task automatic t_hold_and_clear();
    logic p;
    logic [31:0] q;
    p = pass; q = patch;
    repeat (10) @(negedge clk);
    check("R6", "pass held while idle", {31'd0, pass}, {31'd0, p});
    check("R5", "patch held while idle", patch, q);
    stall_mode = 0;
    pulse_start();
    check("R9", "pass cleared by start", {31'd0, pass}, 32'd0);
    check("R9", "patch cleared by start", patch, 32'd0);
    while (rd_req) @(negedge clk);
  endtask

  task automatic t_reset_mid();
    stall_mode = 2;
    pulse_start();
    repeat (30) @(negedge clk);
    check("R1", "busy before reset", {31'd0, rd_req}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "rd_req after mid reset", {31'd0, rd_req}, 32'd0);
    check("R1", "pass after mid reset", {31'd0, pass}, 32'd0);
    check("R1", "patch after mid reset", patch, 32'd0);
    check("R1", "done after mid reset", {31'd0, done}, 32'd0);
    p27_pending = 1'b0;
  endtask

  initial begin
    for (int b = 0; b < 32; b++) img[b] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_example();
    t_corrupt_stall();
    t_lanes();
    t_wrap();
    for (int s = 1; s < 5; s++) t_random(s);
    t_start_ignored();
    t_hold_and_clear();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule